// File: doc/BRIEF.md
# Debug Monitor Entry Controller

This block chooses, every time the chip is reset, whether the core starts in a debug monitor mode or in normal user mode. While reset is held, it samples two inputs: one shows that the IRQ select pin is at the supply level, and the other shows that the reset vector reads as blank. The decision is frozen when reset is released. After that, the select inputs can change freely and the decision does not move.

In monitor mode the block counts security bytes from a host. Each byte is reported by a one-cycle receive strobe. When the last security byte arrives, the block drives a break on its serial transmit line: ten bit times held low. The break tells the host that a command may follow, and the host can measure its length to work out the bit rate. When the line returns high, a ready flag is set and stays set until the next reset.

The block also does two other jobs. It moves the reset, software-interrupt and break vector fetch addresses from page $FF to page $FE while in monitor mode. It also produces the watchdog enable, which is held off in monitor mode while the high-voltage test level is still present.

Top module: `dbgmon_entry`

## Requirements
- R1: While `rst` is high, `monitor_mode` follows `irq_at_vdd AND rvec_blank`. The value present at the last reset cycle is the mode used after release.
- R2: While `rst` is low, changes on `irq_at_vdd` and `rvec_blank` have no effect on `monitor_mode` or on `vec_addr` until the next reset.
- R3: In monitor mode, `tx_line` stays high and `ready` stays low until exactly `SEC_BYTES` (default 8) receive strobes have been seen since reset. Fewer strobes never start a break.
- R4: On the clock edge that samples the final security strobe, `tx_line` goes low. It stays low for exactly `BREAK_BITS * BIT_CLKS` cycles (default 10 x 625), then returns high.
- R5: `ready` rises in the same cycle that `tx_line` returns high after the break. It then stays high until `rst` is asserted, and reset clears it.
- R6: Receive strobes during or after the break have no effect: no second break is sent and `ready` keeps its value.
- R7: In user mode, receive strobes are ignored, `tx_line` stays high and `ready` stays low.
- R8: `vec_addr` is {page, low byte}. The page is $FE in monitor mode and $FF in user mode. `vec_kind` is encoded as 2'b00 reset, 2'b01 software interrupt, 2'b10 break, and 2'b11 is treated as reset. The low byte is $FE for reset and $FC for both software interrupt and break, with bit 0 set by `vec_lo`. So the addresses are $xxFE/$xxFF for reset and $xxFC/$xxFD for software interrupt and break.
- R9: `cop_en` is low whenever `cop_cfg_dis` is high. It is also low in monitor mode while `hv_present` is high. In every other case it is high.
- R10: The security byte count restarts from zero on every reset. Strobes received before a reset never count toward the break that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is captured at its release |
| irq_at_vdd | input | 1 | IRQ select pin is at the supply level |
| rvec_blank | input | 1 | Reset vector reads as blank |
| hv_present | input | 1 | High-voltage test level still applied to IRQ or reset pin |
| cop_cfg_dis | input | 1 | Configuration bit that disables the watchdog |
| rx_byte_stb | input | 1 | One-cycle strobe per byte received from the host |
| vec_kind | input | 2 | Vector being fetched: 00 reset, 01 SWI, 10 break, 11 reset |
| vec_lo | input | 1 | Selects the low (odd) byte of the vector pair |
| monitor_mode | output | 1 | Latched mode: 1 monitor, 0 user |
| tx_line | output | 1 | Serial transmit line, idle high, low during break |
| ready | output | 1 | Break finished; host may send commands |
| cop_en | output | 1 | Watchdog enable |
| vec_addr | output | 16 | Remapped vector fetch address |

## Verification
The bench builds the block with `BIT_CLKS` set to 5, keeping the default eight security bytes and ten break bits. The whole break is then 50 cycles, so the bench can count the low run cycle by cycle and compare it against the expected length several times within a short run. It can also cover cases such as a reset part-way through the byte count, strobes arriving during the break, and the user-mode path.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;

    localparam logic [7:0] PAGE_MON  = 8'hFE;
    localparam logic [7:0] PAGE_USER = 8'hFF;
    localparam logic [7:0] LOW_RESET = 8'hFE;
    localparam logic [7:0] LOW_TRAP  = 8'hFC;

    typedef enum logic [1:0] {
        VK_RESET = 2'b00,
        VK_SWI   = 2'b01,
        VK_BRK   = 2'b10,
        VK_RSVD  = 2'b11
    } vec_kind_e;

    typedef enum logic [1:0] {
        SQ_COLLECT = 2'd0,
        SQ_BREAK   = 2'd1,
        SQ_READY   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [7:0] page;
        logic [7:0] low;
    } vec_addr_t;

    function automatic logic [7:0] vec_low_base(vec_kind_e k);
        case (k)
            VK_SWI, VK_BRK: return LOW_TRAP;
            default:        return LOW_RESET;
        endcase
    endfunction

endpackage

// File: rtl/dbgmon_mode_latch.sv
module dbgmon_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic irq_at_vdd,
    input  logic rvec_blank,
    input  logic hv_present,
    input  logic cop_cfg_dis,
    output logic monitor,
    output logic cop_en
);
    logic mon_q;

    // Tracks the pins while reset is held; freezes at release.
    always_ff @(posedge clk) begin
        if (rst) begin
            mon_q <= irq_at_vdd & rvec_blank;
        end
    end

    assign monitor = mon_q;
    assign cop_en  = ~cop_cfg_dis & ~(mon_q & hv_present);
endmodule

// File: rtl/dbgmon_seq.sv
module dbgmon_seq
    import dbgmon_pkg::*;
#(
    parameter int SEC_BYTES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic monitor,
    input  logic rx_stb,
    input  logic brk_done,
    output logic brk_start,
    output logic ready
);
    localparam int SEC_W = $clog2(SEC_BYTES + 1);

    seq_state_e       st;
    logic [SEC_W-1:0] sec_cnt;
    logic             take;

    assign take      = (st == SQ_COLLECT) && monitor && rx_stb;
    assign brk_start = take && (sec_cnt == SEC_W'(SEC_BYTES - 1));
    assign ready     = (st == SQ_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_COLLECT;
            sec_cnt <= '0;
        end else begin
            case (st)
                SQ_COLLECT: begin
                    if (brk_start)  st <= SQ_BREAK;
                    else if (take)  sec_cnt <= sec_cnt + 1'b1;
                end
                SQ_BREAK: begin
                    if (brk_done) st <= SQ_READY;
                end
                default: st <= SQ_READY;
            endcase
        end
    end
endmodule

// File: rtl/dbgmon_break_gen.sv
module dbgmon_break_gen #(
    parameter int BIT_CLKS   = 625,
    parameter int BREAK_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done,
    output logic tx
);
    localparam int BREAK_CLKS = BIT_CLKS * BREAK_BITS;
    localparam int CNT_W      = (BREAK_CLKS > 1) ? $clog2(BREAK_CLKS) : 1;

    logic             busy;
    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == CNT_W'(BREAK_CLKS - 1));
    assign tx   = ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbgmon_vec_remap.sv
module dbgmon_vec_remap
    import dbgmon_pkg::*;
(
    input  logic        monitor,
    input  logic [1:0]  kind,
    input  logic        lo,
    output logic [15:0] addr
);
    vec_addr_t a;
    logic [7:0] base;

    always_comb begin
        base   = vec_low_base(vec_kind_e'(kind));
        a.page = monitor ? PAGE_MON : PAGE_USER;
        a.low  = {base[7:1], lo};
    end

    assign addr = a;
endmodule

// File: rtl/dbgmon_entry.sv
module dbgmon_entry #(
    parameter int BIT_CLKS   = 625,
    parameter int SEC_BYTES  = 8,
    parameter int BREAK_BITS = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_at_vdd,
    input  logic        rvec_blank,
    input  logic        hv_present,
    input  logic        cop_cfg_dis,
    input  logic        rx_byte_stb,
    input  logic [1:0]  vec_kind,
    input  logic        vec_lo,
    output logic        monitor_mode,
    output logic        tx_line,
    output logic        ready,
    output logic        cop_en,
    output logic [15:0] vec_addr
);
    logic brk_start;
    logic brk_done;

    dbgmon_mode_latch u_mode (
        .clk         (clk),
        .rst         (rst),
        .irq_at_vdd  (irq_at_vdd),
        .rvec_blank  (rvec_blank),
        .hv_present  (hv_present),
        .cop_cfg_dis (cop_cfg_dis),
        .monitor     (monitor_mode),
        .cop_en      (cop_en)
    );

    dbgmon_seq #(.SEC_BYTES(SEC_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .monitor   (monitor_mode),
        .rx_stb    (rx_byte_stb),
        .brk_done  (brk_done),
        .brk_start (brk_start),
        .ready     (ready)
    );

    dbgmon_break_gen #(.BIT_CLKS(BIT_CLKS), .BREAK_BITS(BREAK_BITS)) u_brk (
        .clk   (clk),
        .rst   (rst),
        .start (brk_start),
        .done  (brk_done),
        .tx    (tx_line)
    );

    dbgmon_vec_remap u_vec (
        .monitor (monitor_mode),
        .kind    (vec_kind),
        .lo      (vec_lo),
        .addr    (vec_addr)
    );
endmodule

// File: rtl/dbgmon_entry_chk.sv
module dbgmon_entry_chk #(
    parameter int BIT_CLKS   = 625,
    parameter int BREAK_BITS = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        hv_present,
    input logic        rx_byte_stb,
    input logic        monitor_mode,
    input logic        tx_line,
    input logic        ready,
    input logic        cop_en,
    input logic [15:0] vec_addr
);
    localparam int BREAK_CLKS = BIT_CLKS * BREAK_BITS;

    int low_cnt;
    always_ff @(posedge clk) begin
        if (rst || tx_line) low_cnt <= 0;
        else                low_cnt <= low_cnt + 1;
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(monitor_mode));

    // R3
    break_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_line) |-> ($past(rx_byte_stb) && monitor_mode));

    // R4
    break_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_line) |-> (low_cnt == BREAK_CLKS));

    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R5
    ready_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $rose(tx_line));

    // R7
    user_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !monitor_mode |-> (tx_line && !ready));

    // R8
    page_chk: assert property (@(posedge clk) disable iff (rst)
        monitor_mode |-> (vec_addr[15:8] == 8'hFE));

    // R9
    cop_off_chk: assert property (@(posedge clk) disable iff (rst)
        (monitor_mode && hv_present) |-> !cop_en);
endmodule

bind dbgmon_entry dbgmon_entry_chk #(.BIT_CLKS(BIT_CLKS), .BREAK_BITS(BREAK_BITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hv_present   (hv_present),
    .rx_byte_stb  (rx_byte_stb),
    .monitor_mode (monitor_mode),
    .tx_line      (tx_line),
    .ready        (ready),
    .cop_en       (cop_en),
    .vec_addr     (vec_addr)
);

// File: tb/dbgmon_entry_tb.sv
module dbgmon_entry_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 5;
    localparam int NSEC       = 8;
    localparam int NBRK       = 10;
    localparam int BRK_LEN    = BITC * NBRK;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_at_vdd = 1'b1, rvec_blank = 1'b1;
    logic        hv_present = 1'b1, cop_cfg_dis = 1'b0;
    logic        rx_byte_stb = 1'b0;
    logic [1:0]  vec_kind = 2'b00;
    logic        vec_lo = 1'b0;
    logic        monitor_mode, tx_line, ready, cop_en;
    logic [15:0] vec_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgmon_entry #(.BIT_CLKS(BITC), .SEC_BYTES(NSEC), .BREAK_BITS(NBRK)) u_dut (
        .clk(clk), .rst(rst), .irq_at_vdd(irq_at_vdd), .rvec_blank(rvec_blank),
        .hv_present(hv_present), .cop_cfg_dis(cop_cfg_dis), .rx_byte_stb(rx_byte_stb),
        .vec_kind(vec_kind), .vec_lo(vec_lo), .monitor_mode(monitor_mode),
        .tx_line(tx_line), .ready(ready), .cop_en(cop_en), .vec_addr(vec_addr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic irq, logic blank);
        @(negedge clk);
        rst = 1'b1; irq_at_vdd = irq; rvec_blank = blank;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte();
        @(negedge clk); rx_byte_stb = 1'b1;
        @(negedge clk); rx_byte_stb = 1'b0;
    endtask

    // Driver: the byte that should complete the security sequence queues its expected break.
    task automatic send_bytes(int n, bit last_breaks);
        for (int i = 0; i < n; i++) begin
            if (last_breaks && i == n - 1) exp_q.push_back(BRK_LEN);
            send_byte();
        end
    endtask

    task automatic vec_chk(string req, logic [1:0] k, logic lo, logic [15:0] exp);
        vec_kind = k; vec_lo = lo;
        #1;
        chk(req, {16'h0, vec_addr}, {16'h0, exp});
    endtask

    // Monitor: measures every low run on tx_line and compares against the queue.
    int run = 0;
    always @(negedge clk) begin
        if (rst) begin
            run = 0;
        end else if (!tx_line) begin
            run++;
        end else if (run > 0) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3/R7 unexpected break: actual %0d expected none", run);
            end else begin
                chk("R4 break length", run, exp_q.pop_front());
                chk("R5 ready at line release", {31'h0, ready}, 32'h1);
            end
            run = 0;
        end
    end

    initial begin
        repeat (100000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 monitor entry, reset state
        do_reset(1'b1, 1'b1);
        chk("R1 monitor entry", {31'h0, monitor_mode}, 32'h1);
        chk("R3 idle line after reset", {31'h0, tx_line}, 32'h1);
        chk("R5 ready clear after reset", {31'h0, ready}, 32'h0);
        chk("R9 cop off in monitor with hv", {31'h0, cop_en}, 32'h0);

        // R2 pins ignored after release
        irq_at_vdd = 1'b0; rvec_blank = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 mode held", {31'h0, monitor_mode}, 32'h1);

        // R8 monitor page
        vec_chk("R8 mon reset hi", 2'b00, 1'b0, 16'hFEFE);
        vec_chk("R8 mon reset lo", 2'b00, 1'b1, 16'hFEFF);
        vec_chk("R8 mon swi", 2'b01, 1'b0, 16'hFEFC);
        vec_chk("R8 mon brk", 2'b10, 1'b1, 16'hFEFD);
        vec_chk("R8 mon rsvd", 2'b11, 1'b0, 16'hFEFE);

        // R3 seven bytes: no break
        send_bytes(NSEC - 1, 1'b0);
        repeat (20) @(negedge clk);
        chk("R3 no break before eighth", {31'h0, tx_line}, 32'h1);
        chk("R3 not ready before eighth", {31'h0, ready}, 32'h0);

        // R4 eighth byte, R6 strobe during break
        send_bytes(1, 1'b1);
        repeat (5) @(negedge clk);
        chk("R4 line low in break", {31'h0, tx_line}, 32'h0);
        send_byte();
        repeat (BRK_LEN + 5) @(negedge clk);
        chk("R5 ready set", {31'h0, ready}, 32'h1);
        chk("R4 break compared", exp_q.size(), 0);

        // R6 strobes after ready
        send_bytes(NSEC + 2, 1'b0);
        repeat (10) @(negedge clk);
        chk("R6 ready held", {31'h0, ready}, 32'h1);
        chk("R6 line idle", {31'h0, tx_line}, 32'h1);

        // R9 cop
        hv_present = 1'b0; #1;
        chk("R9 cop on when hv removed", {31'h0, cop_en}, 32'h1);
        cop_cfg_dis = 1'b1; #1;
        chk("R9 cop disabled by config", {31'h0, cop_en}, 32'h0);
        cop_cfg_dis = 1'b0; hv_present = 1'b1;

        // R10 reset part-way through count
        do_reset(1'b1, 1'b1);
        chk("R5 ready cleared by reset", {31'h0, ready}, 32'h0);
        send_bytes(5, 1'b0);
        do_reset(1'b1, 1'b1);
        send_bytes(NSEC - 1, 1'b0);
        repeat (20) @(negedge clk);
        chk("R10 count restarted", {31'h0, tx_line}, 32'h1);
        send_bytes(1, 1'b1);
        repeat (BRK_LEN + 5) @(negedge clk);
        chk("R10 break after fresh eight", {31'h0, ready}, 32'h1);

        // R7 user mode
        do_reset(1'b0, 1'b1);
        chk("R1 user when irq low", {31'h0, monitor_mode}, 32'h0);
        do_reset(1'b1, 1'b0);
        chk("R1 user when vector not blank", {31'h0, monitor_mode}, 32'h0);
        irq_at_vdd = 1'b1; rvec_blank = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 user mode held", {31'h0, monitor_mode}, 32'h0);
        send_bytes(NSEC + 4, 1'b0);
        repeat (20) @(negedge clk);
        chk("R7 no ready in user", {31'h0, ready}, 32'h0);
        chk("R7 line idle in user", {31'h0, tx_line}, 32'h1);
        vec_chk("R8 user reset hi", 2'b00, 1'b0, 16'hFFFE);
        vec_chk("R8 user swi lo", 2'b01, 1'b1, 16'hFFFD);
        vec_chk("R8 user brk hi", 2'b10, 1'b0, 16'hFFFC);
        #1;
        chk("R9 cop on in user with hv", {31'h0, cop_en}, 32'h1);
        chk("R3 no stray breaks", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule